// File: doc/BRIEF.md
# Write-Read Ordering Guard

This block sits between the separate read and write request streams of a pipelined processor and the single memory bus that they share. Because of how the pipeline is built, a write is held back for a while. A read that arrives after the write, even though it was issued later in program order, normally reaches the bus first. For ordinary memory this reordering is harmless and saves cycles. For peripherals whose side effects depend on ordering, however, it can break the program.

The guard keeps one pending write and arbitrates a single bus operation per cycle. Each request carries a program-order tag. When a read is later in program order than the pending write, and either the read address or the write address falls in an enabled protected region, the guard issues the write first. It holds the read off with a stall for one cycle. Outside protected regions the faster read-first order is kept. A protection-enable register chooses, per region, which regions are guarded. Regions are selected by the top address bits, and the register has a default set of guarded regions after reset.

Top module: `wr_order_guard`

## Requirements
- R1: After reset, `bus_valid` and `stall` are low, and the protection register holds `PROT_DEFAULT`. The default is 4'b0111: regions 0, 1 and 2 are guarded and region 3 is not.
- R2: The region of an address is its top `RSEL_W` bits (bits 15:14 with the defaults). Bit i of the protection register guards region i.
- R3: When `cfg_we` is high at a rising edge, `cfg_prot_en` is loaded into the protection register. The new value governs decisions from the next cycle on.
- R4: Some reads are guarded. This holds when a read is valid, a write is pending, and the write is earlier in program order than the read. It also requires that the read address or the pending write address lies in a guarded region. For such a read, `stall` is high and `rd_ready` is low, and the pending write is issued that cycle. The read is issued the cycle after, if it is still presented.
- R5: The guard does not intervene when neither address is in a guarded region. In that case a valid read is accepted and issued at once, ahead of the pending write, and `stall` stays low.
- R6: If the read is earlier in program order than the pending write, the read is issued at once with `stall` low, whatever the regions.
- R7: At most one bus operation issues per cycle. The decision made in a cycle appears on `bus_valid`, `bus_we`, `bus_addr`, `bus_wdata` and `bus_tag` after the next rising edge. A read shows `bus_we`=0 and a write shows `bus_we`=1. With no request, `bus_valid` is low.
- R8: The write path holds one pending write. `wr_ready` is high when nothing is pending or when the pending write issues this cycle. A pending write issues in any cycle without a valid read, and in the guarded case of R4.
- R9: Program order is decided by the wrapping difference of the tags. A write is earlier than a read when (rd_tag - wr_tag) mod 2^TW is non-zero and below 2^(TW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the protection register |
| cfg_prot_en | input | NREG | New protection enables, one bit per region |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_tag | input | TW | Program-order tag of the write |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted and issued this cycle |
| rd_addr | input | AW | Read address |
| rd_tag | input | TW | Program-order tag of the read |
| stall | output | 1 | Read held back to keep program order |
| bus_valid | output | 1 | Bus operation valid (trace of issue order) |
| bus_we | output | 1 | Bus operation is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_tag | output | TW | Program-order tag of the issued operation |

## Verification
The assertions take for granted that the requester keeps a read stable until `rd_ready`, and keeps a write stable until `wr_ready`. They also take for granted that the tags of live requests lie within half the tag range of each other. The random stimulus re-presents a refused request unchanged and draws fresh tags from one running counter, so live tags always stay close. It randomly orders write-before-read or read-before-write, and it spreads addresses over all regions. It also rewrites the protection register now and then, while directed cases pin the guarded, unguarded and older-read situations.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
   typedef enum logic [1:0] {
      ISS_NONE = 2'd0,
      ISS_RD   = 2'd1,
      ISS_WR   = 2'd2
   } iss_sel_t;
endpackage

// File: rtl/wrg_region_chk.sv
module wrg_region_chk #(
   parameter int AW     = 16,
   parameter int RSEL_W = 2,
   localparam int NREG  = 1 << RSEL_W
) (
   input  logic [AW-1:0]   addr,
   input  logic [NREG-1:0] prot_en,
   output logic            hit
);
   logic [RSEL_W-1:0] region;
   logic [NREG-1:0]   hit_vec;

   assign region = addr[AW-1 -: RSEL_W];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      assign hit_vec[i] = prot_en[i] && (region == RSEL_W'(i));
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/wrg_wr_hold.sv
module wrg_wr_hold #(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic [TW-1:0] in_tag,
   input  logic          pop,
   output logic          pend_v,
   output logic [AW-1:0] pend_addr,
   output logic [DW-1:0] pend_data,
   output logic [TW-1:0] pend_tag
);
   assign in_ready = !pend_v || pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
         pend_tag  <= '0;
      end else begin
         if (in_valid && in_ready) begin
            pend_v    <= 1'b1;
            pend_addr <= in_addr;
            pend_data <= in_data;
            pend_tag  <= in_tag;
         end else if (pop) begin
            pend_v <= 1'b0;
         end
      end
   end

   // R8
   wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (pend_v && pend_addr == $past(in_addr) && pend_tag == $past(in_tag)));

   // R8
   pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> pend_v);
endmodule

// File: rtl/wrg_issue.sv
module wrg_issue
   import wrg_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic [TW-1:0] rd_tag,
   input  logic          rd_prot,
   input  logic          pend_v,
   input  logic [TW-1:0] pend_tag,
   input  logic          wr_prot,
   output iss_sel_t      sel,
   output logic          stall,
   output logic          rd_ready
);
   logic signed [TW-1:0] tag_diff;
   logic                 wr_older;

   assign tag_diff = $signed(rd_tag - pend_tag);
   assign wr_older = pend_v && (tag_diff > 0);

   always_comb begin
      sel      = ISS_NONE;
      stall    = 1'b0;
      rd_ready = 1'b0;
      if (rd_valid) begin
         if (wr_older && (rd_prot || wr_prot)) begin
            sel   = ISS_WR;
            stall = 1'b1;
         end else begin
            sel      = ISS_RD;
            rd_ready = 1'b1;
         end
      end else if (pend_v) begin
         sel = ISS_WR;
      end
   end

   // R6
   older_read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && pend_v && !wr_older) |-> (!stall && rd_ready));

   // R5
   unguarded_read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_prot && !wr_prot) |-> !stall);
endmodule

// File: rtl/wr_order_guard.sv
module wr_order_guard
   import wrg_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int TW     = 4,
   parameter int RSEL_W = 2,
   localparam int NREG  = 1 << RSEL_W,
   parameter logic [NREG-1:0] PROT_DEFAULT = NREG'(7)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [NREG-1:0] cfg_prot_en,
   input  logic            wr_valid,
   output logic            wr_ready,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [TW-1:0]   wr_tag,
   input  logic            rd_valid,
   output logic            rd_ready,
   input  logic [AW-1:0]   rd_addr,
   input  logic [TW-1:0]   rd_tag,
   output logic            stall,
   output logic            bus_valid,
   output logic            bus_we,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   output logic [TW-1:0]   bus_tag
);
   if (RSEL_W < 1 || RSEL_W > AW) begin : g_bad_rsel
      $error("wr_order_guard: RSEL_W must be 1..AW");
   end
   if (TW < 2) begin : g_bad_tw
      $error("wr_order_guard: TW must be at least 2");
   end

   logic [NREG-1:0] prot_q;
   logic            rd_prot, wr_prot;
   logic            pend_v;
   logic [AW-1:0]   pend_addr;
   logic [DW-1:0]   pend_data;
   logic [TW-1:0]   pend_tag;
   iss_sel_t        sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prot_q <= PROT_DEFAULT;
      else if (cfg_we) prot_q <= cfg_prot_en;
   end

   wrg_region_chk #(.AW(AW), .RSEL_W(RSEL_W)) u_rd_region (
      .addr(rd_addr), .prot_en(prot_q), .hit(rd_prot));

   wrg_region_chk #(.AW(AW), .RSEL_W(RSEL_W)) u_wr_region (
      .addr(pend_addr), .prot_en(prot_q), .hit(wr_prot));

   wrg_wr_hold #(.AW(AW), .DW(DW), .TW(TW)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .in_valid(wr_valid), .in_ready(wr_ready),
      .in_addr(wr_addr), .in_data(wr_data), .in_tag(wr_tag),
      .pop(sel == ISS_WR),
      .pend_v(pend_v), .pend_addr(pend_addr),
      .pend_data(pend_data), .pend_tag(pend_tag));

   wrg_issue #(.TW(TW)) u_issue (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_prot(rd_prot),
      .pend_v(pend_v), .pend_tag(pend_tag), .wr_prot(wr_prot),
      .sel(sel), .stall(stall), .rd_ready(rd_ready));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_valid <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_tag   <= '0;
      end else begin
         bus_valid <= (sel != ISS_NONE);
         case (sel)
            ISS_RD: begin
               bus_we    <= 1'b0;
               bus_addr  <= rd_addr;
               bus_wdata <= '0;
               bus_tag   <= rd_tag;
            end
            ISS_WR: begin
               bus_we    <= 1'b1;
               bus_addr  <= pend_addr;
               bus_wdata <= pend_data;
               bus_tag   <= pend_tag;
            end
            default: bus_we <= 1'b0;
         endcase
      end
   end

   // R4
   stall_issues_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (bus_valid && bus_we && bus_tag == $past(pend_tag)));

   // R4
   stall_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (rd_valid && !rd_ready));

   // R7
   rd_accept_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> (bus_valid && !bus_we && bus_addr == $past(rd_addr)
                                  && bus_tag == $past(rd_tag)));

   // R7
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && !pend_v) |=> !bus_valid);
endmodule

// File: tb/wr_order_guard_bench.sv
module wr_order_guard_bench;
   localparam int AW = 16, DW = 16, TW = 4, RSEL_W = 2, NREG = 4;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0;
   logic [NREG-1:0] cfg_prot_en = '0;
   logic wr_valid = 0, rd_valid = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [TW-1:0] wr_tag = '0, rd_tag = '0;
   logic wr_ready, rd_ready, stall, bus_valid, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [TW-1:0] bus_tag;

   always #4 clk = ~clk;

   wr_order_guard u_wr_order_guard (.*);

   int tests = 0, fails = 0;
   bit done = 0;

   // bench model
   logic [NREG-1:0] m_prot;
   bit              m_pv;
   logic [AW-1:0]   m_pa;
   logic [DW-1:0]   m_pd;
   logic [TW-1:0]   m_pt;
   bit              e_bv, e_we;
   logic [AW-1:0]   e_addr;
   logic [DW-1:0]   e_data;
   logic [TW-1:0]   e_tag;
   logic [TW-1:0]   seq;
   int              n_stall = 0;

   function automatic bit write_first(logic [TW-1:0] rt, logic [TW-1:0] wt);
      logic [TW-1:0] d = rt - wt;
      return (d != 0) && (d < (1 << (TW-1)));
   endfunction

   function automatic bit guarded(logic [AW-1:0] a, logic [NREG-1:0] p);
      return p[a[AW-1:AW-2]];
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one cycle: inputs already set at negedge; check ready/stall, predict bus
   task automatic step();
      bit guard, x_stall, x_rr, x_wr, pop;
      #1;
      guard   = rd_valid && m_pv && write_first(rd_tag, m_pt)
                && (guarded(rd_addr, m_prot) || guarded(m_pa, m_prot));
      x_stall = guard;
      x_rr    = rd_valid && !guard;
      pop     = m_pv && (guard || !rd_valid);
      x_wr    = !m_pv || pop;
      check(stall == x_stall, guard ? "R4" : "R5", "stall", stall, x_stall);
      check(rd_ready == x_rr, (rd_valid && !guard) ? "R6" : "R4", "rd_ready", rd_ready, x_rr);
      check(wr_ready == x_wr, "R8", "wr_ready", wr_ready, x_wr);
      if (guard) n_stall++;
      e_bv = x_rr || pop;
      if (x_rr) begin
         e_we = 0; e_addr = rd_addr; e_data = '0; e_tag = rd_tag;
      end else if (pop) begin
         e_we = 1; e_addr = m_pa; e_data = m_pd; e_tag = m_pt;
      end
      if (pop) m_pv = 0;
      if (wr_valid && x_wr) begin
         m_pv = 1; m_pa = wr_addr; m_pd = wr_data; m_pt = wr_tag;
      end
      if (cfg_we) m_prot = cfg_prot_en;
      @(negedge clk);
      check(bus_valid == e_bv, "R7", "bus_valid", bus_valid, e_bv);
      if (e_bv) begin
         check(bus_we == e_we, "R7", "bus_we", bus_we, e_we);
         check(bus_addr == e_addr, "R7", "bus_addr", bus_addr, e_addr);
         check(bus_tag == e_tag, "R9", "bus_tag", bus_tag, e_tag);
         if (e_we) check(bus_wdata == e_data, "R8", "bus_wdata", bus_wdata, e_data);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0017));
      m_prot = 4'b0111; m_pv = 0; m_pa = '0; m_pd = '0; m_pt = '0; seq = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(bus_valid == 0, "R1", "bus_valid in reset", bus_valid, 0);
      check(stall == 0, "R1", "stall in reset", stall, 0);
      rst_n = 1;
      @(negedge clk);
      check(bus_valid == 0 && stall == 0, "R1", "idle after reset", {bus_valid, stall}, 0);

      // R4/R2: write to region 1 (guarded by default), read region 3 younger
      wr_valid = 1; wr_addr = 16'h4010; wr_data = 16'hA5A5; wr_tag = 4'd1;
      step();
      wr_valid = 0;
      rd_valid = 1; rd_addr = 16'hC020; rd_tag = 4'd2;
      #1 check(stall == 1, "R4", "guarded by write region", stall, 1);
      step();
      check(bus_we == 1 && bus_tag == 4'd1, "R4", "write first", {bus_we, bus_tag}, {1'b1, 4'd1});
      step();
      check(bus_we == 0 && bus_tag == 4'd2, "R4", "read after", {bus_we, bus_tag}, {1'b0, 4'd2});
      rd_valid = 0;

      // R5: both in region 3 -> read first
      wr_valid = 1; wr_addr = 16'hC100; wr_data = 16'h1234; wr_tag = 4'd3;
      step();
      wr_valid = 0;
      rd_valid = 1; rd_addr = 16'hC200; rd_tag = 4'd4;
      #1 check(stall == 0, "R5", "unguarded read not stalled", stall, 0);
      step();
      check(bus_we == 0 && bus_tag == 4'd4, "R5", "read ahead of write", {bus_we, bus_tag}, {1'b0, 4'd4});
      rd_valid = 0;
      step();
      check(bus_we == 1 && bus_tag == 4'd3, "R8", "write drains when no read", {bus_we, bus_tag}, {1'b1, 4'd3});

      // R6: read older than pending guarded write
      wr_valid = 1; wr_addr = 16'h0008; wr_data = 16'h0F0F; wr_tag = 4'd6;
      step();
      wr_valid = 0;
      rd_valid = 1; rd_addr = 16'h0004; rd_tag = 4'd5;
      #1 check(stall == 0, "R6", "older read not stalled", stall, 0);
      step();
      rd_valid = 0;
      step();

      // R3: enable region 3 only, then region 3 traffic is guarded
      cfg_we = 1; cfg_prot_en = 4'b1000;
      step();
      cfg_we = 0;
      wr_valid = 1; wr_addr = 16'hC300; wr_data = 16'h7777; wr_tag = 4'd7;
      step();
      wr_valid = 0;
      rd_valid = 1; rd_addr = 16'h8000; rd_tag = 4'd8;
      #1 check(stall == 1, "R3", "new enable takes effect", stall, 1);
      step(); step();
      rd_valid = 0;
      // R9 wrap: write tag 15, read tag 0 -> write earlier
      wr_valid = 1; wr_addr = 16'hC400; wr_data = 16'h9999; wr_tag = 4'd15;
      step();
      wr_valid = 0;
      rd_valid = 1; rd_addr = 16'hC500; rd_tag = 4'd0;
      #1 check(stall == 1, "R9", "wrapped tags keep order", stall, 1);
      step(); step();
      rd_valid = 0;
      step();
      seq = 4'd1;

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         bit rd_hold = rd_valid && !rd_ready;
         bit wr_hold = wr_valid && !wr_ready;
         bit new_rd, new_wr;
         new_rd = !rd_hold && ($urandom_range(0, 99) < 55);
         new_wr = !wr_hold && ($urandom_range(0, 99) < 45);
         if (!rd_hold) rd_valid = new_rd;
         if (!wr_hold) wr_valid = new_wr;
         if (new_rd && new_wr && $urandom_range(0, 1)) begin
            rd_tag = seq; seq++; wr_tag = seq; seq++;
         end else begin
            if (new_wr) begin wr_tag = seq; seq++; end
            if (new_rd) begin rd_tag = seq; seq++; end
         end
         if (new_rd) rd_addr = 16'($urandom);
         if (new_wr) begin wr_addr = 16'($urandom); wr_data = 16'($urandom); end
         cfg_we = ($urandom_range(0, 99) < 3);
         cfg_prot_en = 4'($urandom);
         step();
      end
      cfg_we = 0; rd_valid = 0; wr_valid = 0;
      step(); step();
      check(n_stall > 0, "R4", "random run produced stalls", n_stall, 1);
      finish_run();
   end
endmodule